// File: doc/BRIEF.md
# Byte-Multiplexed Pixel Output Formatter

This block sits at the output of a 12-bit converter pipeline in an image-sensor front end. The converter delivers one word per conversion period. The block delays each word by a fixed pipeline latency and then places it on an 8-bit output bus as two bytes. The upper part of the word is driven during the first half of the conversion period and the lower part during the second half. In three-channel mode each word also carries a colour label that steps through red, green and blue, or through blue, green and red when the reverse order is selected. In single-channel mode every word is labelled with one chosen colour.

The block runs from a single clock at twice the conversion rate. A free-running phase register splits each conversion period into a high-byte half and a low-byte half. The converter word is captured at the end of every low half.

The input stream is qualified only by a valid flag and has no ready signal. The converter cannot stall, so the block never applies back-pressure. Every capture slot moves the pipeline forward whether or not its word is valid. Downstream logic must take both bytes in the half-cycles in which they appear. The output enable is active low. It gates the pad drive and the bus value without any clock delay.

Top module: `pxfmt_out`

## Requirements
- R1: While reset is held, `word_valid` is 0, `col_tag` is 3 (none), `byte_hi` is 1 and `bus_data` is 0.
- R2: `byte_hi` is 1 in the first clock of every conversion period and 0 in the second. The first clock after reset is a high half.
- R3: In the high half, with the bus enabled, `bus_data` equals bits 11:4 of the delayed converter word.
- R4: In the low half, with the bus enabled, `bus_data` equals bits 3:0 of the delayed word on bus bits 7:4. Bus bits 3:0 are 0.
- R5: A word, its valid flag and its label, presented during conversion period k, appear on the outputs during period k+3. They hold their values through both halves of that period.
- R6: During the first three conversion periods after reset, `word_valid` is 0.
- R7: In three-channel mode with `rev_order`=0, successive valid words are labelled 0 (red), 1 (green), 2 (blue), repeating.
- R8: In three-channel mode with `rev_order`=1, successive valid words are labelled 2 (blue), 1 (green), 0 (red), repeating.
- R9: In single-channel mode (`three_ch`=0), every valid word is labelled with `mono_sel`. A `mono_sel` value of 3 is labelled 0 (red).
- R10: A change to `three_ch` or `rev_order` in the middle of a colour group has no effect until that group finishes. The change applies from the next first-colour word onward.
- R11: With `oe_n`=1, `bus_drive` is 0 and `bus_data` is 0 in the same cycle. With `oe_n`=0, `bus_drive` is 1.
- R12: A word captured with `adc_valid`=0 comes out with `word_valid`=0 and `col_tag`=3. It does not advance the colour sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the conversion rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_word | input | 12 | Converter word, held for one conversion period |
| adc_valid | input | 1 | Qualifies adc_word |
| three_ch | input | 1 | 1 = three-channel mode, 0 = single-channel mode |
| rev_order | input | 1 | 1 = blue-green-red order, 0 = red-green-blue order |
| mono_sel | input | 2 | Colour used in single-channel mode (0 red, 1 green, 2 blue) |
| oe_n | input | 1 | Active-low output enable |
| bus_data | output | 8 | Byte bus value toward the pads |
| bus_drive | output | 1 | Pad drive enable (high drives, low floats) |
| byte_hi | output | 1 | 1 while the high byte is on the bus |
| word_valid | output | 1 | Valid flag of the word on the bus |
| col_tag | output | 2 | Colour of the word on the bus (0 red, 1 green, 2 blue, 3 none) |

## Verification
A word is captured on the rising edge at the end of the low half of its conversion period. Three captures later it is on the bus: high byte in clock 2(k+3) after reset, low byte in clock 2(k+3)+1. The output enable acts in the same clock, with no register in its path. The bench drives each word on the falling edge that opens a conversion period. It checks the high half one nanosecond after that falling edge and the low half one nanosecond after the next falling edge. Each comparison uses the record that the bench model stored for period k-3, so both halves of every period are checked against a result fixed three periods earlier.

// File: rtl/pxfmt_pkg.sv
package pxfmt_pkg;
  typedef enum logic [1:0] {
    COL_RED   = 2'd0,
    COL_GREEN = 2'd1,
    COL_BLUE  = 2'd2,
    COL_NONE  = 2'd3
  } colour_e;

  localparam int unsigned NUM_COLOURS = 3;
  localparam int unsigned POS_W       = $clog2(NUM_COLOURS);
endpackage

// File: rtl/pxfmt_phase.sv
// Splits each conversion period into a high-byte half and a low-byte half.
module pxfmt_phase (
  input  logic clk,
  input  logic rst_n,
  output logic hi_phase,
  output logic capture
);
  logic lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= 1'b0;
    else        lo_q <= ~lo_q;
  end

  assign hi_phase = ~lo_q;
  // The edge that closes a low half is the capture point of the period.
  assign capture  = lo_q;
endmodule

// File: rtl/pxfmt_colour_seq.sv
// Labels each captured word with its colour. Mode and order are taken
// only when the sequence stands at its first position.
module pxfmt_colour_seq
  import pxfmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       word_ok,
  input  logic       three_ch,
  input  logic       rev_order,
  input  logic [1:0] mono_sel,
  output colour_e    tag
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_COLOURS - 1);

  logic [POS_W-1:0] pos_q;
  logic             mode_q;
  logic             rev_q;
  logic             eff_three;
  logic             eff_rev;
  logic             at_start;

  assign at_start  = (pos_q == '0);
  assign eff_three = at_start ? three_ch  : mode_q;
  assign eff_rev   = at_start ? rev_order : rev_q;

  always_comb begin
    if (!word_ok) begin
      tag = COL_NONE;
    end else if (!eff_three) begin
      tag = (mono_sel == 2'd3) ? COL_RED : colour_e'(mono_sel);
    end else if (eff_rev) begin
      tag = colour_e'(2'(LAST_POS - pos_q));
    end else begin
      tag = colour_e'(2'(pos_q));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      mode_q <= 1'b1;
      rev_q  <= 1'b0;
    end else if (step) begin
      if (at_start) begin
        mode_q <= three_ch;
        rev_q  <= rev_order;
      end
      if (word_ok) begin
        if (!eff_three || pos_q == LAST_POS) pos_q <= '0;
        else                                 pos_q <= pos_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pxfmt_delay.sv
// Fixed-depth delay line that advances only on capture slots.
module pxfmt_delay #(
  parameter int unsigned W     = 15,
  parameter int unsigned DEPTH = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     stg[i] <= RST_VAL;
        else if (shift) stg[i] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     stg[i] <= RST_VAL;
        else if (shift) stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/pxfmt_byte_mux.sv
// Aligns the word in a wider internal field and picks the byte for the phase.
module pxfmt_byte_mux #(
  parameter int unsigned WORD_W = 12,
  parameter int unsigned INT_W  = 14,
  parameter int unsigned BUS_W  = 8
) (
  input  logic [WORD_W-1:0] word,
  input  logic              hi_phase,
  input  logic              oe_n,
  output logic [BUS_W-1:0]  bus_data,
  output logic              bus_drive
);
  localparam int unsigned PAD_W = INT_W - WORD_W;
  localparam int unsigned LO_W  = INT_W - BUS_W;
  localparam int unsigned GAP_W = BUS_W - LO_W;

  logic [INT_W-1:0] aligned;
  logic [BUS_W-1:0] hi_byte;
  logic [BUS_W-1:0] lo_byte;

  assign aligned = {word, {PAD_W{1'b0}}};
  assign hi_byte = aligned[INT_W-1 -: BUS_W];
  assign lo_byte = {aligned[LO_W-1:0], {GAP_W{1'b0}}};

  assign bus_drive = ~oe_n;
  assign bus_data  = oe_n ? '0 : (hi_phase ? hi_byte : lo_byte);
endmodule

// File: rtl/pxfmt_out.sv
module pxfmt_out
  import pxfmt_pkg::*;
#(
  parameter int unsigned WORD_W  = 12,
  parameter int unsigned INT_W   = 14,
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] adc_word,
  input  logic              adc_valid,
  input  logic              three_ch,
  input  logic              rev_order,
  input  logic [1:0]        mono_sel,
  input  logic              oe_n,
  output logic [BUS_W-1:0]  bus_data,
  output logic              bus_drive,
  output logic              byte_hi,
  output logic              word_valid,
  output logic [1:0]        col_tag
);
  localparam int unsigned PAY_W = WORD_W + 3;
  localparam logic [PAY_W-1:0] PAY_RST = {1'b0, COL_NONE, {WORD_W{1'b0}}};

  logic              hi_phase;
  logic              capture;
  colour_e           in_tag;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;
  logic [WORD_W-1:0] out_word;

  pxfmt_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_phase (hi_phase),
    .capture  (capture)
  );

  pxfmt_colour_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (capture),
    .word_ok   (adc_valid),
    .three_ch  (three_ch),
    .rev_order (rev_order),
    .mono_sel  (mono_sel),
    .tag       (in_tag)
  );

  assign pay_in = {adc_valid, in_tag, adc_word};

  pxfmt_delay #(
    .W       (PAY_W),
    .DEPTH   (LATENCY),
    .RST_VAL (PAY_RST)
  ) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (capture),
    .din   (pay_in),
    .dout  (pay_out)
  );

  assign out_word   = pay_out[WORD_W-1:0];
  assign col_tag    = pay_out[WORD_W+1:WORD_W];
  assign word_valid = pay_out[PAY_W-1];
  assign byte_hi    = hi_phase;

  pxfmt_byte_mux #(
    .WORD_W (WORD_W),
    .INT_W  (INT_W),
    .BUS_W  (BUS_W)
  ) u_mux (
    .word      (out_word),
    .hi_phase  (hi_phase),
    .oe_n      (oe_n),
    .bus_data  (bus_data),
    .bus_drive (bus_drive)
  );
endmodule

// File: rtl/pxfmt_out_chk.sv
module pxfmt_out_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       oe_n,
  input logic       byte_hi,
  input logic       word_valid,
  input logic [1:0] col_tag,
  input logic [7:0] bus_data,
  input logic       bus_drive
);
  logic [3:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cyc_q <= '0;
    else if (cyc_q != 4'hF) cyc_q <= cyc_q + 1'b1;
  end

  // R2
  a_r2_half_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    byte_hi |=> !byte_hi);
  a_r2_half_return: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_hi |=> byte_hi);
  // R5: word attributes hold across both halves of a period
  a_r5_hold_period: assert property (@(posedge clk) disable iff (!rst_n)
    byte_hi |=> ($stable(word_valid) && $stable(col_tag)));
  // R6: pipeline fill
  a_r6_fill_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q < 4'd6) |-> !word_valid);
  // R11
  a_r11_released: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!bus_drive && bus_data == 8'h00));
  // R12
  a_r12_invalid_untagged: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> (col_tag == 2'd3));
endmodule

bind pxfmt_out pxfmt_out_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .oe_n       (oe_n),
  .byte_hi    (byte_hi),
  .word_valid (word_valid),
  .col_tag    (col_tag),
  .bus_data   (bus_data),
  .bus_drive  (bus_drive)
);

// File: tb/pxfmt_out_test.sv
module pxfmt_out_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] adc_word = '0;
  logic        adc_valid = 1'b0;
  logic        three_ch = 1'b1;
  logic        rev_order = 1'b0;
  logic [1:0]  mono_sel = '0;
  logic        oe_n = 1'b0;
  logic [7:0]  bus_data;
  logic        bus_drive;
  logic        byte_hi;
  logic        word_valid;
  logic [1:0]  col_tag;

  always #2 clk = ~clk;

  pxfmt_out uut (
    .clk(clk), .rst_n(rst_n), .adc_word(adc_word), .adc_valid(adc_valid),
    .three_ch(three_ch), .rev_order(rev_order), .mono_sel(mono_sel), .oe_n(oe_n),
    .bus_data(bus_data), .bus_drive(bus_drive), .byte_hi(byte_hi),
    .word_valid(word_valid), .col_tag(col_tag)
  );

  int n_run = 0;
  int n_fail = 0;
  int k = 0;
  logic [11:0] e_word [2048];
  logic        e_val  [2048];
  logic [1:0]  e_tag  [2048];
  string       e_req  [2048];
  string       req_override = "";
  int          m_pos = 0;
  bit          m_three = 1'b1;
  bit          m_rev = 1'b0;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h (period %0d)", rq, what, act, exp, k);
    end
  endtask

  // Requirement model of the labelling rules (R7-R10, R12)
  task automatic model_capture(input logic [11:0] w, input bit v, input bit tc,
                               input bit rv, input logic [1:0] sel);
    bit eff3, effr;
    logic [1:0] t;
    string rq;
    eff3 = (m_pos == 0) ? tc : m_three;
    effr = (m_pos == 0) ? rv : m_rev;
    if (!v) begin
      t = 2'd3; rq = "R12";
    end else if (!eff3) begin
      t = (sel == 2'd3) ? 2'd0 : sel; rq = "R9";
    end else begin
      t = effr ? 2'(2 - m_pos) : 2'(m_pos); rq = effr ? "R8" : "R7";
    end
    if (req_override != "" && v) rq = req_override;
    if (m_pos == 0) begin m_three = tc; m_rev = rv; end
    if (v) m_pos = (!eff3 || m_pos == 2) ? 0 : m_pos + 1;
    e_word[k] = w; e_val[k] = v; e_tag[k] = t; e_req[k] = rq;
  endtask

  task automatic step(input logic [11:0] w, input bit v, input bit tc,
                      input bit rv, input logic [1:0] sel, input bit oe);
    logic [11:0] ew;
    logic        ev;
    logic [1:0]  et;
    string       rq;
    @(negedge clk);
    adc_word = w; adc_valid = v; three_ch = tc; rev_order = rv; mono_sel = sel; oe_n = oe;
    #1;
    if (k >= 3) begin
      ew = e_word[k-3]; ev = e_val[k-3]; et = e_tag[k-3]; rq = e_req[k-3];
    end else begin
      ew = '0; ev = 1'b0; et = 2'd3; rq = "R6";
    end
    chk("R2", "byte_hi high half", int'(byte_hi), 1);
    chk("R11", "bus_drive", int'(bus_drive), oe ? 0 : 1);
    if (oe) chk("R11", "released bus", int'(bus_data), 0);
    else    chk("R3", "high byte", int'(bus_data), int'(ew[11:4]));
    chk((k < 3) ? "R6" : "R5", "word_valid", int'(word_valid), int'(ev));
    chk(ev ? rq : "R12", "col_tag", int'(col_tag), int'(et));
    model_capture(w, v, tc, rv, sel);
    @(negedge clk);
    #1;
    chk("R2", "byte_hi low half", int'(byte_hi), 0);
    if (oe) chk("R11", "released bus low", int'(bus_data), 0);
    else    chk("R4", "low byte", int'(bus_data), int'({ew[3:0], 4'h0}));
    chk("R5", "word_valid hold", int'(word_valid), int'(ev));
    chk("R5", "col_tag hold", int'(col_tag), int'(et));
    k++;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk("R1", "word_valid in reset", int'(word_valid), 0);
    chk("R1", "col_tag in reset", int'(col_tag), 3);
    chk("R1", "byte_hi in reset", int'(byte_hi), 1);
    chk("R1", "bus_data in reset", int'(bus_data), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    // R6 fill and R7 forward order
    for (int i = 0; i < 9; i++) step(12'h100 + 12'(i * 37), 1, 1, 0, 0, 0);
    // R10: order change in the middle of a group
    step(12'hA11, 1, 1, 0, 0, 0);
    req_override = "R10";
    step(12'hA22, 1, 1, 1, 0, 0);
    step(12'hA33, 1, 1, 1, 0, 0);
    req_override = "";
    for (int i = 0; i < 6; i++) step(12'hB00 + 12'(i), 1, 1, 1, 0, 0);
    // R10: mode change in the middle of a group
    step(12'h5A5, 1, 1, 0, 0, 0);
    req_override = "R10";
    step(12'h5A6, 1, 0, 0, 2'd2, 0);
    step(12'h5A7, 1, 0, 0, 2'd2, 0);
    req_override = "";
    // R9: single-channel labels including selector value 3
    for (int s = 0; s < 4; s++) step(12'h3C0 + 12'(s), 1, 0, 0, 2'(s), 0);
    // R12: invalid words in a group
    step(12'h111, 1, 1, 0, 0, 0);
    step(12'h222, 0, 1, 0, 0, 0);
    step(12'h333, 1, 1, 0, 0, 0);
    step(12'h444, 0, 1, 0, 0, 0);
    step(12'h555, 1, 1, 0, 0, 0);
    // R11: bus released
    step(12'h666, 1, 1, 0, 0, 1);
    step(12'h777, 1, 1, 0, 0, 1);
    step(12'h888, 1, 1, 0, 0, 0);
    // R3 and R4 extremes
    step(12'hFFF, 1, 1, 0, 0, 0);
    step(12'h000, 1, 1, 0, 0, 0);
    step(12'h00F, 1, 1, 0, 0, 0);
    step(12'hF00, 1, 1, 0, 0, 0);

    // constrained random mix
    begin
      bit tc = 1'b1;
      bit rv = 1'b0;
      logic [1:0] sel = 2'd1;
      for (int i = 0; i < 600; i++) begin
        if ($urandom_range(15) == 0) tc = ~tc;
        if ($urandom_range(15) == 0) rv = ~rv;
        if ($urandom_range(15) == 0) sel = 2'($urandom_range(3));
        step(12'($urandom), $urandom_range(7) != 0, tc, rv, sel,
             $urandom_range(9) == 0);
      end
    end
    // flush
    repeat (3) step(12'h000, 0, 1, 0, 0, 0);

    summary();
    $finish;
  end
endmodule